// File: doc/BRIEF.md
# Region Write-Protected RAM

This block is a synchronous single-port RAM of 4096 eight-bit words that blocks writes per region. The memory space is cut into eight equal regions of 512 words. A region mask register holds one permission bit per region. While the protection guard input is high, a memory write lands only if the permission bit of its target region is set. While the guard is low, every qualified write lands and the mask is ignored.

The bus carries one extra address bit above the memory space. When that bit is high, the access goes to register space, where the mask register sits at offset 0. The mask can be loaded only while the privileged-mode input is high. A write needs both the bus write enable and the write qualifier. Reads are never blocked, and their data appears one clock after the read enable. A write that is refused leaves storage unchanged and raises a drop pulse for one cycle.

A small access state machine records the class of the access accepted at each edge. ACC_IDLE means no access. ACC_READ means a read only. ACC_WRITE means a memory write that landed. ACC_MASK means the mask was loaded. ACC_BLOCK means a write was refused. From any state, the next state is chosen as follows:
- A qualified write to offset 0 of register space goes to ACC_MASK when privileged and to ACC_BLOCK when not.
- A qualified write to any other register-space offset goes to ACC_IDLE.
- A qualified memory write goes to ACC_WRITE when the guard is low or the region bit is set, and to ACC_BLOCK otherwise.
- With no qualified write, a read enable goes to ACC_READ and no access goes to ACC_IDLE.

The drop pulse is high exactly while the state is ACC_BLOCK.

Top module: `regionlock_ram`

## Requirements
- R1: During and after reset the mask reads back as 0xFF (all regions writable), the drop pulse is low and the read data is 0x00.
- R2: A read enable at a clock edge makes the read data equal the addressed word after that edge, whatever the mask, guard and privilege inputs are.
- R3: A write enable with the write qualifier low changes nothing and raises no drop pulse.
- R4: With the guard high, a qualified memory write to a region whose mask bit is set stores the data. The region index is address bits 11:9, and mask bit n belongs to region n.
- R5: With the guard high, a qualified memory write to a region whose mask bit is clear leaves memory unchanged and raises the drop pulse in the cycle after the edge.
- R6: With the guard low, every qualified memory write stores its data and raises no drop pulse.
- R7: A qualified write with address bit 12 set and bits 11:0 equal to zero, made while privileged, loads the mask from write data bits 7:0. A read of that address returns the mask.
- R8: The same mask write made while not privileged leaves the mask unchanged and raises the drop pulse.
- R9: Each refused write gives a drop pulse of one cycle. Refused writes on consecutive edges give a pulse on each of the following cycles, and the pulse falls once refused writes stop.
- R10: Writes to register-space offsets other than 0 have no effect and raise no drop pulse. Reads of those offsets return 0x00.
- R11: A read and a write to the same word at the same edge return the word's previous contents, and the new data is read afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 13 | Bit 12 selects register space; bits 11:0 give the word |
| bus_we_i | input | 1 | Write enable |
| bus_wq_i | input | 1 | Write qualifier, needed together with the write enable |
| bus_wdata_i | input | 8 | Write data |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 8 | Read data, valid one clock after the read enable |
| priv_mode_i | input | 1 | Privileged mode; permits loading the mask |
| guard_en_i | input | 1 | Enables region protection |
| drop_pulse_o | output | 1 | One-cycle pulse for each refused write |

## Verification
Memory writes are tried against the low and high edges of a blocked region, so both ends of the address slice are covered. They are also tried in an open neighbouring region, which shows that a wrong slice of the region index would be caught. The same blocked address is written with the guard high and then low, which separates the mask from the guard. Mask writes are made privileged and unprivileged, which separates privilege gating from region gating. A write with the qualifier low, writes to unused register offsets, a read and write at the same edge, and refused writes held over two edges cover the corner cases of the pulse and read ordering.

// File: rtl/regionlock_pkg.sv
package regionlock_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_MASK,
        ACC_BLOCK
    } acc_state_e;

    typedef struct packed {
        logic is_reg;
        logic mask_hit;
    } addr_kind_t;

endpackage

// File: rtl/regionlock_decode.sv
module regionlock_decode #(
    parameter int ADDR_W      = 12,
    parameter int REGION_BITS = 3,
    parameter int MASK_OFS    = 0
) (
    input  logic [ADDR_W:0]                   addr_i,
    output regionlock_pkg::addr_kind_t        kind_o,
    output logic [REGION_BITS-1:0]            region_o
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(MASK_OFS);

    always_comb begin
        kind_o.is_reg   = addr_i[ADDR_W];
        kind_o.mask_hit = addr_i[ADDR_W] && (addr_i[ADDR_W-1:0] == OFS);
        region_o        = addr_i[ADDR_W-1 -: REGION_BITS];
    end
endmodule

// File: rtl/regionlock_mask.sv
module regionlock_mask #(
    parameter int REGIONS = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [REGIONS-1:0] value_i,
    output logic [REGIONS-1:0] mask_o
);
    for (genvar g = 0; g < REGIONS; g++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                mask_o[g] <= 1'b1;
            end else if (load_i) begin
                mask_o[g] <= value_i[g];
            end
        end
    end
endmodule

// File: rtl/regionlock_store.sv
module regionlock_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            cells[addr_i] <= wdata_i;
        end
    end

    // read-first: the old word is captured at the same edge as a write
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_o <= '0;
        end else if (re_i) begin
            rdata_o <= cells[addr_i];
        end
    end
endmodule

// File: rtl/regionlock_ram.sv
module regionlock_ram #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int REGION_BITS = 3,
    parameter int MASK_OFS    = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W:0]   bus_addr_i,
    input  logic              bus_we_i,
    input  logic              bus_wq_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_re_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              priv_mode_i,
    input  logic              guard_en_i,
    output logic              drop_pulse_o
);
    import regionlock_pkg::*;

    localparam int REGIONS = 1 << REGION_BITS;

    acc_state_e               state_q;
    acc_state_e               state_d;
    addr_kind_t               kind;
    logic [REGION_BITS-1:0]   region;
    logic [REGIONS-1:0]       mask_q;
    logic [DATA_W-1:0]        mask_ext;
    logic                     wr_try;
    logic                     mem_we;
    logic                     mask_we;
    logic                     mem_re;
    logic [DATA_W-1:0]        mem_rdata;
    logic                     rd_src_q;
    logic [DATA_W-1:0]        reg_rd_q;

    regionlock_decode #(
        .ADDR_W      (ADDR_W),
        .REGION_BITS (REGION_BITS),
        .MASK_OFS    (MASK_OFS)
    ) u_decode (
        .addr_i   (bus_addr_i),
        .kind_o   (kind),
        .region_o (region)
    );

    regionlock_mask #(
        .REGIONS (REGIONS)
    ) u_mask (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (mask_we),
        .value_i (bus_wdata_i[REGIONS-1:0]),
        .mask_o  (mask_q)
    );

    regionlock_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (mem_we),
        .re_i    (mem_re),
        .addr_i  (bus_addr_i[ADDR_W-1:0]),
        .wdata_i (bus_wdata_i),
        .rdata_o (mem_rdata)
    );

    if (REGIONS < DATA_W) begin : g_pad
        assign mask_ext = {{(DATA_W-REGIONS){1'b0}}, mask_q};
    end else begin : g_nopad
        assign mask_ext = mask_q[DATA_W-1:0];
    end

    assign wr_try = bus_we_i && bus_wq_i;
    assign mem_re = bus_re_i && !kind.is_reg;

    // transition logic
    always_comb begin
        state_d = ACC_IDLE;
        if (wr_try) begin
            if (kind.mask_hit) begin
                state_d = priv_mode_i ? ACC_MASK : ACC_BLOCK;
            end else if (kind.is_reg) begin
                state_d = ACC_IDLE;
            end else if (!guard_en_i || mask_q[region]) begin
                state_d = ACC_WRITE;
            end else begin
                state_d = ACC_BLOCK;
            end
        end else if (bus_re_i) begin
            state_d = ACC_READ;
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        mem_we       = 1'b0;
        mask_we      = 1'b0;
        drop_pulse_o = (state_q == ACC_BLOCK);
        unique case (state_d)
            ACC_IDLE:  ;
            ACC_READ:  ;
            ACC_WRITE: mem_we  = 1'b1;
            ACC_MASK:  mask_we = 1'b1;
            ACC_BLOCK: ;
            default:   ;
        endcase
    end

    // register-space read path
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_src_q <= 1'b0;
            reg_rd_q <= '0;
        end else if (bus_re_i) begin
            rd_src_q <= kind.is_reg;
            reg_rd_q <= kind.mask_hit ? mask_ext : '0;
        end
    end

    assign bus_rdata_o = rd_src_q ? reg_rd_q : mem_rdata;
endmodule

// File: rtl/regionlock_ram_chk.sv
module regionlock_ram_chk #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int REGION_BITS = 3,
    parameter int MASK_OFS    = 0
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic [ADDR_W:0]             bus_addr_i,
    input logic                        bus_we_i,
    input logic                        bus_wq_i,
    input logic [DATA_W-1:0]           bus_wdata_i,
    input logic                        priv_mode_i,
    input logic                        guard_en_i,
    input logic [(1<<REGION_BITS)-1:0] mask_q,
    input logic                        drop_pulse_o
);
    localparam int REGIONS = 1 << REGION_BITS;
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(MASK_OFS);

    logic qual_wr;
    logic mem_tgt;
    logic mask_tgt;
    logic bit_open;

    assign qual_wr  = bus_we_i && bus_wq_i;
    assign mem_tgt  = !bus_addr_i[ADDR_W];
    assign mask_tgt = bus_addr_i[ADDR_W] && (bus_addr_i[ADDR_W-1:0] == OFS);
    assign bit_open = mask_q[bus_addr_i[ADDR_W-1 -: REGION_BITS]];

    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (mask_q == '1 && !drop_pulse_o));

    assert_qual_needed_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_we_i && !bus_wq_i) |=> !drop_pulse_o);

    assert_region_block_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_wr && mem_tgt && guard_en_i && !bit_open) |=> drop_pulse_o);

    assert_guard_off_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_wr && mem_tgt && !guard_en_i) |=> !drop_pulse_o);

    assert_mask_load_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_wr && mask_tgt && priv_mode_i) |=> (mask_q == $past(bus_wdata_i[REGIONS-1:0])));

    assert_mask_keep_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_wr && mask_tgt && !priv_mode_i) |=> ($stable(mask_q) && drop_pulse_o));

    assert_drop_cause_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        drop_pulse_o |-> $past(qual_wr));
endmodule

bind regionlock_ram regionlock_ram_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_BITS (REGION_BITS),
    .MASK_OFS    (MASK_OFS)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_addr_i   (bus_addr_i),
    .bus_we_i     (bus_we_i),
    .bus_wq_i     (bus_wq_i),
    .bus_wdata_i  (bus_wdata_i),
    .priv_mode_i  (priv_mode_i),
    .guard_en_i   (guard_en_i),
    .mask_q       (mask_q),
    .drop_pulse_o (drop_pulse_o)
);

// File: tb/regionlock_ram_tb.sv
`timescale 1ns/100ps
module regionlock_ram_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic        we = 1'b0;
    logic        wq = 1'b0;
    logic [7:0]  wdata = '0;
    logic        re = 1'b0;
    logic [7:0]  rdata;
    logic        priv = 1'b0;
    logic        guard = 1'b1;
    logic        drop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [12:0] MASK_ADDR = 13'h1000;

    always #2.5 clk = ~clk;

    regionlock_ram u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .bus_addr_i   (addr),
        .bus_we_i     (we),
        .bus_wq_i     (wq),
        .bus_wdata_i  (wdata),
        .bus_re_i     (re),
        .bus_rdata_o  (rdata),
        .priv_mode_i  (priv),
        .guard_en_i   (guard),
        .drop_pulse_o (drop)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d, input logic q,
                            output logic dr);
        addr = a; wdata = d; we = 1'b1; wq = q;
        @(posedge clk); @(negedge clk);
        dr = drop;
        we = 1'b0; wq = 1'b0;
    endtask

    task automatic do_read(input logic [12:0] a, output logic [7:0] d);
        addr = a; re = 1'b1;
        @(posedge clk); @(negedge clk);
        d = rdata;
        re = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 rdata after reset", rdata, 8'h00);
        check("R1 drop after reset", {7'b0, drop}, 8'h00);
        do_read(MASK_ADDR, d);
        check("R1 mask reset value", d, 8'hFF);
    endtask

    task automatic t_open_writes;
        logic dr; logic [7:0] d;
        do_write(13'h000, 8'hA5, 1'b1, dr); check("R4 drop region0", {7'b0, dr}, 8'h00);
        do_write(13'h200, 8'h55, 1'b1, dr); check("R4 drop region1", {7'b0, dr}, 8'h00);
        do_write(13'h400, 8'h34, 1'b1, dr);
        do_write(13'hE01, 8'h3C, 1'b1, dr); check("R4 drop region7", {7'b0, dr}, 8'h00);
        do_read(13'h000, d); check("R2 R4 read 0x000", d, 8'hA5);
        do_read(13'h200, d); check("R2 R4 read 0x200", d, 8'h55);
        do_read(13'hE01, d); check("R2 R4 read 0xE01", d, 8'h3C);
    endtask

    task automatic t_qualifier;
        logic dr; logic [7:0] d;
        do_write(13'h000, 8'h11, 1'b0, dr);
        check("R3 no drop without qualifier", {7'b0, dr}, 8'h00);
        do_read(13'h000, d);
        check("R3 memory unchanged", d, 8'hA5);
    endtask

    task automatic t_mask_load;
        logic dr; logic [7:0] d;
        priv = 1'b1;
        do_write(MASK_ADDR, 8'hFD, 1'b1, dr);
        priv = 1'b0;
        check("R7 no drop on privileged load", {7'b0, dr}, 8'h00);
        do_read(MASK_ADDR, d);
        check("R7 mask readback", d, 8'hFD);
    endtask

    task automatic t_region_block;
        logic dr; logic [7:0] d;
        do_write(13'h200, 8'h77, 1'b1, dr);
        check("R5 drop on blocked low edge", {7'b0, dr}, 8'h01);
        @(posedge clk); @(negedge clk);
        check("R9 drop falls after one cycle", {7'b0, drop}, 8'h00);
        do_write(13'h3FF, 8'h66, 1'b1, dr);
        check("R5 drop on blocked high edge", {7'b0, dr}, 8'h01);
        do_read(13'h200, d);
        check("R5 R2 blocked word kept and readable", d, 8'h55);
        do_write(13'h1FF, 8'h21, 1'b1, dr);
        check("R4 open region0 top no drop", {7'b0, dr}, 8'h00);
        do_read(13'h1FF, d);
        check("R4 open region0 top stored", d, 8'h21);
    endtask

    task automatic t_priv_denied;
        logic dr; logic [7:0] d;
        do_write(MASK_ADDR, 8'h00, 1'b1, dr);
        check("R8 drop on unprivileged load", {7'b0, dr}, 8'h01);
        do_read(MASK_ADDR, d);
        check("R8 mask unchanged", d, 8'hFD);
    endtask

    task automatic t_guard_off;
        logic dr; logic [7:0] d;
        guard = 1'b0;
        do_write(13'h200, 8'h99, 1'b1, dr);
        guard = 1'b1;
        check("R6 no drop with guard off", {7'b0, dr}, 8'h00);
        do_read(13'h200, d);
        check("R6 write stored with guard off", d, 8'h99);
    endtask

    task automatic t_back_to_back;
        addr = 13'h280; wdata = 8'h01; we = 1'b1; wq = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 first pulse", {7'b0, drop}, 8'h01);
        @(posedge clk); @(negedge clk);
        check("R9 second pulse", {7'b0, drop}, 8'h01);
        we = 1'b0; wq = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 pulse ends", {7'b0, drop}, 8'h00);
    endtask

    task automatic t_reg_space;
        logic dr; logic [7:0] d;
        priv = 1'b1;
        do_write(13'h1005, 8'h00, 1'b1, dr);
        priv = 1'b0;
        check("R10 no drop at unused offset", {7'b0, dr}, 8'h00);
        do_read(MASK_ADDR, d);
        check("R10 mask untouched", d, 8'hFD);
        do_read(13'h1005, d);
        check("R10 unused offset reads zero", d, 8'h00);
    endtask

    task automatic t_same_edge;
        logic [7:0] d;
        addr = 13'h400; wdata = 8'h12; we = 1'b1; wq = 1'b1; re = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R11 read returns old word", rdata, 8'h34);
        we = 1'b0; wq = 1'b0; re = 1'b0;
        do_read(13'h400, d);
        check("R11 new word follows", d, 8'h12);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 drop during reset", {7'b0, drop}, 8'h00);
        rst = 1'b0;
        t_reset();
        t_open_writes();
        t_qualifier();
        t_mask_load();
        t_region_block();
        t_priv_denied();
        t_guard_off();
        t_back_to_back();
        t_reg_space();
        t_same_edge();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule